// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block keeps recently used page-table entries so that a virtual address can be turned into a physical address without walking the page table. A virtual address has two parts: a virtual page number and a page offset. The low bits of the page number pick a set. The remaining upper bits are compared against the tags stored in every way of that set. On a hit, the stored physical page number is joined to the untouched offset to form the physical address. On a miss, the block reports the miss. Some outside agent is then expected to fetch the mapping and hand it back through the refill port.

Each entry holds a valid bit, a dirty bit, a tag and a physical page number. A refill for a page that is not yet present goes into the way named by that set's round-robin pointer. A refill for a page that is already present updates that entry in place. A write lookup that hits marks the entry dirty. A flush input invalidates every entry in one cycle. Lookups take one cycle: the response is registered and reflects the contents before any update made in the same cycle.

With the default parameters the block has 32-bit virtual and physical addresses, 4 KB pages, 128 entries and 4 ways. That gives 32 sets, a 5-bit set index and a 15-bit tag.

Top module: `xlate_buf`

## Requirements
- R1: After reset every entry is invalid and all response outputs are low, so the first lookup of any address misses.
- R2: A lookup presented with lk_valid_i high produces rsp_valid_o high exactly one cycle later, with exactly one of rsp_hit_o and rsp_miss_o high. With no lookup, all three are low in the following cycle.
- R3: Virtual address bits [11:0] appear unchanged as rsp_paddr_o[11:0]. On a hit, rsp_paddr_o[31:12] is the stored physical page number. On a miss, those bits are zero.
- R4: The set is chosen by virtual address bits [16:12], and bits [31:17] form the compared tag. A refill's page number uses the same split: bits [4:0] select the set and bits [19:5] form the tag. An entry is found only by an address that matches both its set and its tag.
- R5: A refill whose page is absent from its set writes the way named by that set's pointer and sets that entry valid. Each pointer starts at way 0 after reset and steps by one, wrapping modulo 4, on every such refill. The fifth new page refilled into a set therefore replaces the first.
- R6: A refill whose page is already valid in its set overwrites that entry's physical page number and dirty bit in place. The set's pointer does not move, and no duplicate entry is created.
- R7: A write lookup (lk_write_i high) that hits sets the entry's dirty bit. rsp_dirty_o reports the dirty bit as it was before the lookup, and is low on a miss. Read lookups leave the dirty bit unchanged. A write that misses allocates nothing.
- R8: A flush clears every valid bit in one cycle. A lookup in the same cycle sees the contents from before the flush. A refill in the same cycle is discarded. The round-robin pointers keep their values.
- R9: A lookup in the same cycle as a refill sees the contents from before the refill.
- R10: A refill loads the entry's dirty bit from fill_dirty_i. When a refill and a write hit target the same entry in the same cycle, the refill's dirty value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries |
| lk_valid_i | input | 1 | Lookup request |
| lk_write_i | input | 1 | Lookup is a write access |
| lk_vaddr_i | input | 32 | Virtual address to translate |
| fill_valid_i | input | 1 | Refill request |
| fill_vpn_i | input | 20 | Virtual page number of the refill |
| fill_ppn_i | input | 20 | Physical page number of the refill |
| fill_dirty_i | input | 1 | Dirty bit loaded by the refill |
| rsp_valid_o | output | 1 | Response present |
| rsp_hit_o | output | 1 | Translation found |
| rsp_miss_o | output | 1 | Translation absent |
| rsp_dirty_o | output | 1 | Dirty bit of the hit entry before the lookup |
| rsp_paddr_o | output | 32 | Physical address |

## Verification
The hardest cases to reach from the ports are the ones where several events fall on the same entry in the same cycle. One is a write hit and a refill of the same page together. Another is a lookup that coincides with a flush or a refill. A third is an in-place update landing between victim refills, which must leave the pointer where it was. Directed sequences first fill one set past its four ways to force a wrap of the pointer. They then stack these collisions on purpose. After that, a long stretch of random traffic confined to three sets and six tags keeps lookups, refills and flushes colliding, while a bench-side model of the contents supplies every expected response.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int unsigned DEF_VA_W      = 32;
  localparam int unsigned DEF_PA_W      = 32;
  localparam int unsigned DEF_PAGE_BITS = 12;
  localparam int unsigned DEF_ENTRIES   = 128;
  localparam int unsigned DEF_WAYS      = 4;

  typedef enum logic [1:0] {
    FILL_NONE   = 2'd0,
    FILL_UPDATE = 2'd1,
    FILL_VICTIM = 2'd2
  } fill_kind_e;
endpackage

// File: rtl/xlate_way_match.sv
module xlate_way_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 15,
  parameter int unsigned WAY_W = 2
) (
  input  logic [WAYS-1:0]            vld_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic [WAYS-1:0]            hit_vec_o,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec_o[w] = vld_i[w] && (tags_i[w] == tag_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec_o[w]) way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/xlate_rr_ptr.sv
module xlate_rr_ptr #(
  parameter int unsigned SETS  = 32,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned IDX_W = 5,
  parameter int unsigned WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [WAY_W-1:0] ptr_o
);
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

  logic [WAY_W-1:0] ptr_q [SETS];
  logic [WAY_W-1:0] ptr_step;

  assign ptr_o    = ptr_q[idx_i];
  assign ptr_step = (ptr_o == LAST_WAY) ? '0 : ptr_o + WAY_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (adv_i) begin
      ptr_q[idx_i] <= ptr_step;
    end
  end

  // R5: a victim refill moves its set's pointer to the next way
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> (ptr_q[$past(idx_i)] == (($past(ptr_o) == LAST_WAY) ? '0 : $past(ptr_o) + WAY_W'(1))));
endmodule

// File: rtl/xlate_buf.sv
module xlate_buf
  import xlate_pkg::*;
#(
  parameter int unsigned VA_W      = DEF_VA_W,
  parameter int unsigned PA_W      = DEF_PA_W,
  parameter int unsigned PAGE_BITS = DEF_PAGE_BITS,
  parameter int unsigned ENTRIES   = DEF_ENTRIES,
  parameter int unsigned WAYS      = DEF_WAYS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush_i,
  input  logic                      lk_valid_i,
  input  logic                      lk_write_i,
  input  logic [VA_W-1:0]           lk_vaddr_i,
  input  logic                      fill_valid_i,
  input  logic [VA_W-PAGE_BITS-1:0] fill_vpn_i,
  input  logic [PA_W-PAGE_BITS-1:0] fill_ppn_i,
  input  logic                      fill_dirty_i,
  output logic                      rsp_valid_o,
  output logic                      rsp_hit_o,
  output logic                      rsp_miss_o,
  output logic                      rsp_dirty_o,
  output logic [PA_W-1:0]           rsp_paddr_o
);
  localparam int unsigned SETS  = ENTRIES / WAYS;
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned WAY_W = $clog2(WAYS);
  localparam int unsigned VPN_W = VA_W - PAGE_BITS;
  localparam int unsigned TAG_W = VPN_W - IDX_W;
  localparam int unsigned PPN_W = PA_W - PAGE_BITS;

  // entry storage
  logic [SETS-1:0][WAYS-1:0]   vld_q, vld_d;
  logic [SETS-1:0][WAYS-1:0]   dirty_q, dirty_d;
  logic [WAYS-1:0][TAG_W-1:0]  tag_q [SETS];
  logic [WAYS-1:0][PPN_W-1:0]  ppn_q [SETS];

  // lookup decode
  logic [IDX_W-1:0]     lk_idx;
  logic [TAG_W-1:0]     lk_tag;
  logic [PAGE_BITS-1:0] lk_off;
  logic [WAYS-1:0]      lk_hit_vec;
  logic                 lk_hit;
  logic [WAY_W-1:0]     lk_way;
  logic                 lk_dirty_set;

  assign lk_off = lk_vaddr_i[PAGE_BITS-1:0];
  assign lk_idx = lk_vaddr_i[PAGE_BITS +: IDX_W];
  assign lk_tag = lk_vaddr_i[PAGE_BITS+IDX_W +: TAG_W];

  xlate_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) i_lk_match (
    .vld_i     (vld_q[lk_idx]),
    .tags_i    (tag_q[lk_idx]),
    .tag_i     (lk_tag),
    .hit_vec_o (lk_hit_vec),
    .hit_o     (lk_hit),
    .way_o     (lk_way)
  );

  // R6: at most one way of a set can match, since refills never duplicate a page
  a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid_i |-> $onehot0(lk_hit_vec));

  // refill decode
  logic [IDX_W-1:0] fill_idx;
  logic [TAG_W-1:0] fill_tag;
  logic [WAYS-1:0]  fill_hit_vec;
  logic             fill_hit;
  logic [WAY_W-1:0] fill_match_way;
  logic [WAY_W-1:0] victim_way;
  logic [WAY_W-1:0] fill_way;
  fill_kind_e       fill_kind;
  logic             fill_we;

  assign fill_idx = fill_vpn_i[IDX_W-1:0];
  assign fill_tag = fill_vpn_i[VPN_W-1:IDX_W];

  xlate_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) i_fill_match (
    .vld_i     (vld_q[fill_idx]),
    .tags_i    (tag_q[fill_idx]),
    .tag_i     (fill_tag),
    .hit_vec_o (fill_hit_vec),
    .hit_o     (fill_hit),
    .way_o     (fill_match_way)
  );

  always_comb begin
    if (!fill_valid_i || flush_i) fill_kind = FILL_NONE;
    else if (fill_hit)            fill_kind = FILL_UPDATE;
    else                          fill_kind = FILL_VICTIM;
  end

  assign fill_we  = (fill_kind != FILL_NONE);
  assign fill_way = fill_hit ? fill_match_way : victim_way;

  xlate_rr_ptr #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)) i_rr_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (fill_kind == FILL_VICTIM),
    .idx_i (fill_idx),
    .ptr_o (victim_way)
  );

  // next state of the valid and dirty bits
  assign lk_dirty_set = lk_valid_i && lk_write_i && lk_hit;

  always_comb begin
    vld_d   = vld_q;
    dirty_d = dirty_q;
    if (lk_dirty_set) dirty_d[lk_idx][lk_way] = 1'b1;
    if (flush_i) begin
      vld_d = '0;
    end else if (fill_we) begin
      vld_d[fill_idx][fill_way]   = 1'b1;
      dirty_d[fill_idx][fill_way] = fill_dirty_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      dirty_q <= '0;
    end else begin
      vld_q   <= vld_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_we) begin
      tag_q[fill_idx][fill_way] <= fill_tag;
      ppn_q[fill_idx][fill_way] <= fill_ppn_i;
    end
  end

  // R8: nothing stays valid after a flush cycle
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (vld_q == '0));

  // R7: a write hit leaves its entry dirty unless a refill or flush claims it
  a_r7_write_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_dirty_set && !flush_i && !(fill_we && fill_idx == lk_idx && fill_way == lk_way))
      |=> dirty_q[$past(lk_idx)][$past(lk_way)]);

  // registered response
  logic             rsp_valid_q, rsp_hit_q, rsp_dirty_q;
  logic [PA_W-1:0]  rsp_paddr_q, rsp_paddr_d;

  assign rsp_paddr_d = {(lk_hit ? ppn_q[lk_idx][lk_way] : {PPN_W{1'b0}}), lk_off};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_dirty_q <= 1'b0;
      rsp_paddr_q <= '0;
    end else begin
      rsp_valid_q <= lk_valid_i;
      rsp_hit_q   <= lk_valid_i && lk_hit;
      rsp_dirty_q <= lk_valid_i && lk_hit && dirty_q[lk_idx][lk_way];
      if (lk_valid_i) rsp_paddr_q <= rsp_paddr_d;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_hit_o   = rsp_hit_q;
  assign rsp_miss_o  = rsp_valid_q && !rsp_hit_q;
  assign rsp_dirty_o = rsp_dirty_q;
  assign rsp_paddr_o = rsp_paddr_q;

  // R2: a response follows every lookup and carries exactly one verdict
  a_r2_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid_i |=> (rsp_valid_o && (rsp_hit_o ^ rsp_miss_o)));
  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid_i |=> !(rsp_valid_o || rsp_hit_o || rsp_miss_o));

  // R3: offset copied through; a miss carries a zero page number
  a_r3_offset_copy: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid_i |=> (rsp_paddr_o[PAGE_BITS-1:0] == $past(lk_off)));
  a_r3_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss_o |-> (rsp_paddr_o[PA_W-1:PAGE_BITS] == '0));
endmodule

// File: tb/test_xlate_buf.sv
module test_xlate_buf;
  localparam int CLK_PERIOD = 10;
  localparam int SETS = 32;
  localparam int WAYS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic        lk_valid_i = 1'b0;
  logic        lk_write_i = 1'b0;
  logic [31:0] lk_vaddr_i = '0;
  logic        fill_valid_i = 1'b0;
  logic [19:0] fill_vpn_i = '0;
  logic [19:0] fill_ppn_i = '0;
  logic        fill_dirty_i = 1'b0;
  logic        rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_dirty_o;
  logic [31:0] rsp_paddr_o;

  xlate_buf i_xlate_buf (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .lk_valid_i(lk_valid_i), .lk_write_i(lk_write_i), .lk_vaddr_i(lk_vaddr_i),
    .fill_valid_i(fill_valid_i), .fill_vpn_i(fill_vpn_i), .fill_ppn_i(fill_ppn_i),
    .fill_dirty_i(fill_dirty_i),
    .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_miss_o(rsp_miss_o),
    .rsp_dirty_o(rsp_dirty_o), .rsp_paddr_o(rsp_paddr_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit          v;
    bit          h;
    bit          d;
    logic [31:0] pa;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  // reference contents, kept from the requirements
  bit          m_vld [SETS][WAYS];
  bit          m_dirty [SETS][WAYS];
  logic [14:0] m_tag [SETS][WAYS];
  logic [19:0] m_ppn [SETS][WAYS];
  int          m_ptr [SETS];

  function automatic logic [31:0] va(input int tag, input int idx, input int off);
    return {15'(tag), 5'(idx), 12'(off)};
  endfunction

  function automatic logic [19:0] vpn(input int tag, input int idx);
    return {15'(tag), 5'(idx)};
  endfunction

  function automatic int find(input int idx, input logic [14:0] tag);
    for (int w = 0; w < WAYS; w++)
      if (m_vld[idx][w] && m_tag[idx][w] == tag) return w;
    return -1;
  endfunction

  task automatic step(input bit lk, input bit wr, input logic [31:0] a,
                      input bit fl, input logic [19:0] fv, input logic [19:0] fp,
                      input bit fd, input bit fsh, input string req);
    exp_t e;
    int   li, lw, fi, fw;
    @(negedge clk);
    lk_valid_i = lk; lk_write_i = wr; lk_vaddr_i = a;
    fill_valid_i = fl; fill_vpn_i = fv; fill_ppn_i = fp; fill_dirty_i = fd;
    flush_i = fsh;
    li = int'(a[16:12]);
    lw = find(li, a[31:17]);
    e.v = lk; e.h = lk && (lw >= 0);
    e.d = e.h && m_dirty[li][lw];
    e.pa = {(e.h ? m_ppn[li][lw] : 20'h0), a[11:0]};
    e.req = req;
    exp_q.push_back(e);
    if (fsh) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) m_vld[s][w] = 1'b0;
    end else begin
      if (lk && wr && lw >= 0) m_dirty[li][lw] = 1'b1;
      if (fl) begin
        fi = int'(fv[4:0]);
        fw = find(fi, fv[19:5]);
        if (fw < 0) begin
          fw = m_ptr[fi];
          m_ptr[fi] = (m_ptr[fi] + 1) % WAYS;
        end
        m_vld[fi][fw] = 1'b1; m_tag[fi][fw] = fv[19:5];
        m_ppn[fi][fw] = fp;   m_dirty[fi][fw] = fd;
      end
    end
  endtask

  task automatic look(input bit wr, input logic [31:0] a, input string req);
    step(1'b1, wr, a, 1'b0, '0, '0, 1'b0, 1'b0, req);
  endtask

  task automatic fill(input logic [19:0] fv, input logic [19:0] fp, input bit fd, input string req);
    step(1'b0, 1'b0, '0, 1'b1, fv, fp, fd, 1'b0, req);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b0, "R2");
  endtask

  // monitor: compares each registered response against the queued expectation
  initial begin
    exp_t e;
    bit   bad;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        n_checks++;
        bad = (rsp_valid_o !== e.v) || (rsp_hit_o !== e.h) ||
              (rsp_miss_o !== (e.v && !e.h)) || (rsp_dirty_o !== e.d) ||
              (e.v && rsp_paddr_o !== e.pa);
        if (bad) begin
          n_fail++;
          $display("FAIL %s: got v=%0b h=%0b m=%0b d=%0b pa=%h, expected v=%0b h=%0b m=%0b d=%0b pa=%h",
                   e.req, rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_dirty_o, rsp_paddr_o,
                   e.v, e.h, e.v && !e.h, e.d, e.pa);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got no completion, expected run to end");
    finish_run();
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      m_ptr[s] = 0;
      for (int w = 0; w < WAYS; w++) begin
        m_vld[s][w] = 1'b0; m_dirty[s][w] = 1'b0; m_tag[s][w] = '0; m_ppn[s][w] = '0;
      end
    end
    #(CLK_PERIOD * 3 + 1);
    // R1: outputs low while in reset
    n_checks++;
    if ({rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_dirty_o} !== 4'b0) begin
      n_fail++;
      $display("FAIL R1: got %b, expected 0000", {rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_dirty_o});
    end
    @(negedge clk);
    rst_n = 1'b1;

    idle();                                        // R2 quiet cycle
    look(1'b0, va(1, 3, 'h123), "R1");             // empty after reset: miss, page bits zero
    fill(vpn(1, 3), 20'hABCDE, 1'b0, "R5");
    look(1'b0, va(1, 3, 'h123), "R3");             // hit, {ABCDE,123}
    look(1'b0, va(1, 4, 'h456), "R4");             // same tag, other set: miss
    look(1'b0, va(2, 3, 'h789), "R4");             // same set, other tag: miss
    look(1'b1, va(1, 3, 'h001), "R7");             // write hit reports old dirty 0
    look(1'b0, va(1, 3, 'h002), "R7");             // now dirty 1
    look(1'b1, va(9, 3, 'h003), "R7");             // write miss
    look(1'b0, va(9, 3, 'h003), "R7");             // still absent
    fill(vpn(2, 3), 20'h00002, 1'b0, "R5");
    fill(vpn(3, 3), 20'h00003, 1'b0, "R5");
    fill(vpn(4, 3), 20'h00004, 1'b0, "R5");
    fill(vpn(5, 3), 20'h00005, 1'b0, "R5");        // wraps, replaces tag 1
    look(1'b0, va(1, 3, 'h010), "R5");             // evicted
    for (int t = 2; t <= 5; t++) look(1'b0, va(t, 3, 'h020 + t), "R5");
    fill(vpn(3, 3), 20'h33333, 1'b1, "R6");        // in-place update, pointer stays
    look(1'b0, va(3, 3, 'h0FF), "R6");
    fill(vpn(6, 3), 20'h00006, 1'b0, "R6");        // goes to the pointer way (held tag 2)
    look(1'b0, va(2, 3, 'h0AA), "R6");
    look(1'b0, va(3, 3, 'h0AB), "R6");
    look(1'b0, va(6, 3, 'h0AC), "R6");
    step(1'b1, 1'b0, va(7, 7, 'h555), 1'b1, vpn(7, 7), 20'h77777, 1'b0, 1'b0, "R9");
    look(1'b0, va(7, 7, 'h556), "R9");
    step(1'b1, 1'b1, va(7, 7, 'h557), 1'b1, vpn(7, 7), 20'h77778, 1'b0, 1'b0, "R10");
    look(1'b0, va(7, 7, 'h558), "R10");            // fill dirty 0 wins over write hit
    fill(vpn(7, 7), 20'h77779, 1'b1, "R10");
    look(1'b0, va(7, 7, 'h559), "R10");            // dirty 1 from refill
    step(1'b1, 1'b0, va(4, 3, 'h600), 1'b1, vpn(8, 8), 20'h88888, 1'b0, 1'b1, "R8");
    look(1'b0, va(4, 3, 'h601), "R8");             // flushed
    look(1'b0, va(8, 8, 'h602), "R8");             // refill during flush discarded
    look(1'b0, va(7, 7, 'h603), "R8");
    for (int t = 10; t < 15; t++) fill(vpn(t, 3), 20'(t), 1'b0, "R8");
    for (int t = 10; t < 15; t++) look(1'b0, va(t, 3, t), "R8");
    // random traffic over a few sets and tags
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1,
           va($urandom_range(5, 0), $urandom_range(2, 0), $urandom_range(4095, 0)),
           $urandom_range(2, 0) == 0, vpn($urandom_range(5, 0), $urandom_range(2, 0)),
           20'($urandom), $urandom_range(1, 0) == 1, $urandom_range(60, 0) == 0, "R5 R6 R7 R10");
    end
    idle();
    idle();
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule